// File: doc/BRIEF.md
# Square-Wave Tone Channel with Distortion, High-Pass and Ring Effects

This block is one tone voice of a sound generator. A 12-bit down-counter, advanced only on a 250 kHz enable tick, divides that tick by a programmed reload value. Each time the counter wraps, a one-bit state register either toggles, which gives a plain square wave, or takes a bit from a pseudo-random source, which gives a distorted tone. The block holds three short free-running polynomial shift registers (4, 5 and 7 bits) that step on every tick and serve as those sources. An outside noise bit can take the place of the 7-bit source.

Two effects follow the wave. A high-pass effect clears the state whenever a linked channel's final output falls. A ring modulator makes the output the XNOR of the state and another channel's final output. A parent places several copies side by side and wires their final outputs to one another. All pins are plain control and level signals. No data stream crosses the edge, so there is no valid/ready handshake and no back-pressure.

Top module: `snd_tone_chan`

## Requirements
- R1: When `tick_i` is low, the counter and the shift registers keep their values. The state changes only through a high-pass clear (R7).
- R2: On a tick with the counter at 0, the counter loads `reload_i` and a wrap event occurs. On a tick with a nonzero counter, the counter decrements by one. A reload value N therefore gives a wrap every N+1 ticks. After reset the counter is 0, so the first tick wraps.
- R3: With `dist_sel_i` = 0, each wrap inverts the state.
- R4: The three shift registers are 4, 5 and 7 bits wide, with feedback masks 0xC, 0x14 and 0x60. They reset to all ones. On every tick, each one drops bit 0, shifts right by one, and XORs in its mask when the dropped bit was 1.
- R5: `dist_sel_i` values 1, 2 and 3 select the 4-bit, 5-bit and 7-bit register. On a wrap, the selected register's bit 0, as it stood before that tick's step, becomes the new state.
- R6: With `sub_noise_i` = 1 and `dist_sel_i` = 3, `noise_bit_i` is sampled on a wrap in place of the 7-bit register.
- R7: With `hp_en_i` = 1, a falling edge on `hp_link_i` clears the state at the next clock edge. A falling edge means the pin was 1 at the previous clock edge and is 0 now. The clear wins over a wrap in the same cycle.
- R8: `tone_o` equals the state when `ring_en_i` = 0. When `ring_en_i` = 1 it equals the XNOR of the state and `ring_i`, and it follows `ring_i` without a clock.
- R9: Reset (`rst_n` low) sets the state to 0, the counter to 0 and the stored link level to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 250 kHz enable pulse, one clock wide |
| reload_i | input | 12 | Divider reload value |
| dist_sel_i | input | 2 | 0 toggle, 1 4-bit, 2 5-bit, 3 7-bit source |
| sub_noise_i | input | 1 | Replace the 7-bit source with `noise_bit_i` |
| noise_bit_i | input | 1 | Noise channel's polynomial output bit |
| hp_en_i | input | 1 | High-pass effect enable |
| hp_link_i | input | 1 | Linked channel's final output |
| ring_en_i | input | 1 | Ring modulator enable |
| ring_i | input | 1 | Other channel's final output for ring modulation |
| tone_o | output | 1 | Channel's final output bit |

## Verification
A counter wrap and a high-pass clear can land in the same clock cycle. When they do, the fixed processing order requires the clear to win. The bench forces this case directly: it sets the reload to 0 so every tick wraps, then lowers the linked output in the same cycle as a tick. It checks that the output is 0 afterwards, where a toggle alone would have given 1. Randomly driven ticks and link transitions also produce many further coincidences, and a cycle-by-cycle model built from the requirements judges each of them.

// File: rtl/snd_tone_pkg.sv
package snd_tone_pkg;
  localparam int CNT_W    = 12;
  localparam int NUM_POLY = 3;
  localparam int POLY_W    [NUM_POLY] = '{4, 5, 7};
  localparam int POLY_MASK [NUM_POLY] = '{'hC, 'h14, 'h60};

  typedef enum logic [1:0] {
    DIST_OFF = 2'd0,
    DIST_P4  = 2'd1,
    DIST_P5  = 2'd2,
    DIST_P7  = 2'd3
  } dist_e;
endpackage

// File: rtl/snd_poly.sv
module snd_poly #(
  parameter int W    = 4,
  parameter int MASK = 'hC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic bit_o
);
  localparam logic [W-1:0] MASK_V = W'(MASK);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= '1;
    else if (step_i) sr_q <= (sr_q >> 1) ^ (sr_q[0] ? MASK_V : '0);
  end

  assign bit_o = sr_q[0];

  // R4: a mask with its top bit set keeps the register away from zero
  a_r4_nonzero: assert property (@(posedge clk) disable iff (!rst_n) sr_q != '0);
  // R1: no step without the tick
  a_r1_poly_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(sr_q));
endmodule

// File: rtl/snd_tone_div.sv
module snd_tone_div #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [CW-1:0] reload_i,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_o) cnt_q <= reload_i;
    else if (tick_i) cnt_q <= cnt_q - 1'b1;
  end

  // R2: decrement on a tick when nonzero
  a_r2_count: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R2: load on wrap
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == '0) |=> cnt_q == $past(reload_i));
  // R1: idle without a tick
  a_r1_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/snd_tone_core.sv
module snd_tone_core (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic dist_on_i,
  input  logic dist_bit_i,
  input  logic hp_en_i,
  input  logic hp_link_i,
  input  logic ring_en_i,
  input  logic ring_i,
  output logic tone_o
);
  logic state_q, state_d;
  logic link_q;
  logic hp_clear;

  assign hp_clear = hp_en_i && link_q && !hp_link_i;

  always_comb begin
    state_d = state_q;
    if (wrap_i) state_d = dist_on_i ? dist_bit_i : ~state_q;
    if (hp_clear) state_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      link_q  <= hp_link_i;
    end
  end

  assign tone_o = ring_en_i ? ~(state_q ^ ring_i) : state_q;

  // R7: a falling link edge with the effect on leaves the state low
  a_r7_hp_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_en_i && $fell(hp_link_i)) |=> !state_q);
  // R1: without wrap or clear the state holds
  a_r1_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_i && !(hp_en_i && $fell(hp_link_i))) |=> $stable(state_q));
  // R3: plain toggle on a wrap with no clear
  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && !dist_on_i && !(hp_en_i && $fell(hp_link_i))) |=> state_q != $past(state_q));
endmodule

// File: rtl/snd_tone_chan.sv
module snd_tone_chan
  import snd_tone_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [1:0]       dist_sel_i,
  input  logic             sub_noise_i,
  input  logic             noise_bit_i,
  input  logic             hp_en_i,
  input  logic             hp_link_i,
  input  logic             ring_en_i,
  input  logic             ring_i,
  output logic             tone_o
);
  logic [NUM_POLY-1:0] poly_bits;
  logic                wrap;
  logic                dist_bit;
  dist_e               sel;

  for (genvar g = 0; g < NUM_POLY; g++) begin : g_poly
    snd_poly #(.W(POLY_W[g]), .MASK(POLY_MASK[g])) u_poly (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (tick_i),
      .bit_o  (poly_bits[g])
    );
  end

  snd_tone_div #(.CW(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_i),
    .reload_i (reload_i),
    .wrap_o   (wrap)
  );

  assign sel = dist_e'(dist_sel_i);

  always_comb begin
    unique case (sel)
      DIST_P4: dist_bit = poly_bits[0];
      DIST_P5: dist_bit = poly_bits[1];
      DIST_P7: dist_bit = sub_noise_i ? noise_bit_i : poly_bits[2];
      default: dist_bit = 1'b0;
    endcase
  end

  snd_tone_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrap_i     (wrap),
    .dist_on_i  (sel != DIST_OFF),
    .dist_bit_i (dist_bit),
    .hp_en_i    (hp_en_i),
    .hp_link_i  (hp_link_i),
    .ring_en_i  (ring_en_i),
    .ring_i     (ring_i),
    .tone_o     (tone_o)
  );
endmodule

// File: tb/snd_tone_chan_test.sv
`timescale 1ns/1ps
module snd_tone_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [11:0] reload_i = '0;
  logic [1:0]  dist_sel_i = '0;
  logic        sub_noise_i = 1'b0;
  logic        noise_bit_i = 1'b0;
  logic        hp_en_i = 1'b0;
  logic        hp_link_i = 1'b0;
  logic        ring_en_i = 1'b0;
  logic        ring_i = 1'b0;
  logic        tone_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  logic [11:0] m_cnt;
  logic [7:0]  m_p4, m_p5, m_p7;
  logic        m_st, m_lk;

  always #2 clk = ~clk;

  snd_tone_chan uut (.*);

  function automatic logic [7:0] pstep(input logic [7:0] s, input logic [7:0] m);
    return (s >> 1) ^ (s[0] ? m : 8'h00);
  endfunction

  function automatic logic exp_out();
    return ring_en_i ? ~(m_st ^ ring_i) : m_st;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: tone_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: update model from driven inputs, then compare after the edge
  task automatic cyc(input string tag);
    logic fall, wrap, smp, nst;
    fall = hp_en_i && m_lk && !hp_link_i;
    wrap = tick_i && (m_cnt == 0);
    case (dist_sel_i)
      2'd1: smp = m_p4[0];
      2'd2: smp = m_p5[0];
      2'd3: smp = sub_noise_i ? noise_bit_i : m_p7[0];
      default: smp = 1'b0;
    endcase
    nst = m_st;
    if (wrap) nst = (dist_sel_i != 0) ? smp : ~m_st;
    if (fall) nst = 1'b0;
    if (tick_i) begin
      m_cnt = wrap ? reload_i : m_cnt - 12'd1;
      m_p4 = pstep(m_p4, 8'h0C) & 8'h0F;
      m_p5 = pstep(m_p5, 8'h14) & 8'h1F;
      m_p7 = pstep(m_p7, 8'h60) & 8'h7F;
    end
    m_st = nst;
    m_lk = hp_link_i;
    @(posedge clk);
    #1;
    check(tag, tone_o, exp_out());
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_cnt = 0; m_p4 = 8'h0F; m_p5 = 8'h1F; m_p7 = 8'h7F; m_st = 0; m_lk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset state", tone_o, 1'b0);

    // R8: ring modulation follows ring_i without a clock
    ring_en_i = 1'b1; ring_i = 1'b0; #1;
    check("R8 xnor 0,0", tone_o, 1'b1);
    ring_i = 1'b1; #1;
    check("R8 xnor 0,1", tone_o, 1'b0);
    ring_en_i = 1'b0; ring_i = 1'b0;
    @(negedge clk);

    // R1: no tick, no change
    reload_i = 12'd2;
    for (int i = 0; i < 5; i++) cyc("R1 idle");

    // R2: reload 2 -> wrap every third tick; first tick wraps from 0
    tick_i = 1'b1;
    for (int i = 0; i < 9; i++) begin
      cyc("R2 period");
      check("R2 phase", tone_o, ((i / 3) % 2 == 0) ? 1'b1 : 1'b0);
    end
    tick_i = 1'b0;

    // R7: wrap and high-pass clear in the same cycle; clear wins
    reload_i = 12'd0; hp_en_i = 1'b1; hp_link_i = 1'b1;
    cyc("R7 setup");
    tick_i = 1'b1;
    cyc("R7 setup tick");
    hp_link_i = 1'b0;
    cyc("R7 collision");
    check("R7 clear beats wrap", tone_o, 1'b0);
    tick_i = 1'b0; hp_en_i = 1'b0;
    cyc("R7 after");

    // R6: substituted noise bit sampled on wrap
    tick_i = 1'b1; dist_sel_i = 2'd3; sub_noise_i = 1'b1;
    noise_bit_i = 1'b1;
    cyc("R6 subst");
    check("R6 noise=1", tone_o, 1'b1);
    noise_bit_i = 1'b0;
    cyc("R6 subst");
    check("R6 noise=0", tone_o, 1'b0);
    sub_noise_i = 1'b0; tick_i = 1'b0;

    // random mix
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 6000; i++) begin
      tick_i      = ($urandom % 3) == 0;
      if ($urandom % 40 == 0) reload_i = ($urandom % 8 == 0) ? 12'($urandom) : 12'($urandom % 6);
      if ($urandom % 60 == 0) dist_sel_i = 2'($urandom);
      if ($urandom % 60 == 0) sub_noise_i = $urandom;
      noise_bit_i = $urandom;
      if ($urandom % 50 == 0) hp_en_i = $urandom;
      if ($urandom % 4 == 0) hp_link_i = ~hp_link_i;
      if ($urandom % 50 == 0) ring_en_i = $urandom;
      ring_i = $urandom;
      if (ring_en_i)                                  cyc("R8 random");
      else if (hp_en_i)                               cyc("R7 random");
      else if (dist_sel_i == 2'd3 && sub_noise_i)     cyc("R6 random");
      else if (dist_sel_i == 2'd3)                    cyc("R5 random");
      else if (dist_sel_i != 2'd0)                    cyc("R4 random");
      else                                            cyc("R3 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule